// File: doc/BRIEF.md
# Chip-Select Output Bank

This block holds eight general-purpose output bits that a serial-peripheral master can use as chip-select lines. Two write strobes reach it from a register decoder. The first loads a configuration word. Its upper byte flags which pins carry a chip select, and its lower byte gives each pin an output inversion. The second strobe takes a command word that changes stored output bits without a read-modify-write cycle. Each bit of the command's upper byte forces the stored bit of its pin to one. Each bit of the lower byte forces the stored bit of its pin to zero.

Each pad is driven by the stored output bit XOR its inversion bit. After reset every stored bit is one, so active-low selects start deasserted. The configuration starts at zero, which means no pin is a chip select and no pin is inverted. The chip-select flags are passed out to the pin multiplexer that sits next to this bank.

Top module: `cs_out_bank`

## Requirements
- R1: After reset, pad_out is all ones and cs_sel is all zeros. The stored state is all ones and the configuration is zero.
- R2: A command write with bit N+n set and bit n clear stores a one for pin n. Here N is the pin count, 8 by default.
- R3: A command write with bit n set stores a zero for pin n.
- R4: If one command write sets both bit N+n and bit n, the clear wins and pin n stores zero.
- R5: A command write leaves unchanged the stored bit of every pin whose set and clear bits are both zero.
- R6: pad_out[n] equals the stored bit of pin n XOR configuration bit n, the inversion bit.
- R7: After a configuration write, cs_sel[n] equals bit N+n of the written word.
- R8: A configuration write of zero makes every pad follow its stored bit without inversion and clears every cs_sel bit.
- R9: A command write of 0xFF00 drives all eight stored bits to one.
- R10: A configuration write does not change any stored output bit, and without a command write the stored bits keep their value.
- R11: Both registers take the new value on the clock edge where their strobe is high. The outputs show it from that edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word: [15:8] chip-select flags, [7:0] inversion mask |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 16 | Command word: [15:8] set bits, [7:0] clear bits |
| pad_out | output | 8 | Pad drive levels |
| cs_sel | output | 8 | Per-pin chip-select flag for the pin multiplexer |

## Verification
A stored bit or inversion bit that is wrong shows up on pad_out one edge after the write that caused it. The bench reads pads right after each write to catch it. A bit that changes when it should not, such as a clear losing to a set or an untouched pin moving, can stay hidden until that pin is read. For that reason every pad is compared after every write, not only the addressed pins. Inversion errors are separated from stored-state errors by toggling the mask back to zero and checking that the earlier levels come back.

// File: rtl/cs_out_bank.sv
module cs_out_bank #(
  parameter int NPINS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [2*NPINS-1:0] cfg_wdata,
  input  logic               cmd_we,
  input  logic [2*NPINS-1:0] cmd_wdata,
  output logic [NPINS-1:0]   pad_out,
  output logic [NPINS-1:0]   cs_sel
);
  localparam int W = 2 * NPINS;

  logic [NPINS-1:0] lvl_q, inv_q, csf_q;
  logic [NPINS-1:0] set_m, clr_m;

  assign set_m = cmd_wdata[W-1:NPINS];
  assign clr_m = cmd_wdata[NPINS-1:0];

  // clear has priority over set on the same pin
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl_q <= '1;
    else if (cmd_we) lvl_q <= (lvl_q | set_m) & ~clr_m;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_q <= '0;
      csf_q <= '0;
    end else if (cfg_we) begin
      inv_q <= cfg_wdata[NPINS-1:0];
      csf_q <= cfg_wdata[W-1:NPINS];
    end
  end

  assign pad_out = lvl_q ^ inv_q;
  assign cs_sel  = csf_q;

  p_reset_r1: assert property (@(posedge clk) $rose(rst_n) |-> (pad_out == '1 && cs_sel == '0));

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we |=> ((lvl_q & $past(set_m & ~clr_m)) == $past(set_m & ~clr_m)));

  p_clear_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we |=> ((lvl_q & $past(clr_m)) == '0));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we |=> (((lvl_q ^ $past(lvl_q)) & ~$past(set_m | clr_m)) == '0));

  p_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we |=> $stable(lvl_q));

  p_cfg_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cs_sel == $past(cfg_wdata[W-1:NPINS])));

  p_pad_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && !cmd_we) |=> $stable(pad_out));
endmodule

// File: tb/sim_cs_out_bank.sv
module sim_cs_out_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cmd_we = 1'b0;
  logic [15:0] cfg_wdata = '0, cmd_wdata = '0;
  logic [7:0] pad_out, cs_sel;

  int checks = 0, errors = 0;
  logic [7:0] m_lvl, m_inv, m_cs;
  logic [15:0] exp_q[$];
  string tag_q[$];
  event chk_ev;
  bit done = 0;

  always #5 clk = ~clk;

  cs_out_bank u0 (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
                  .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .pad_out(pad_out), .cs_sel(cs_sel));

  task automatic push_exp(input string tag);
    exp_q.push_back({m_cs, m_lvl ^ m_inv});
    tag_q.push_back(tag);
  endtask

  task automatic do_cmd(input logic [15:0] d, input string tag);
    @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = d;
    m_lvl = (m_lvl | d[15:8]) & ~d[7:0];
    push_exp(tag);
    @(negedge clk);
    cmd_we = 1'b0;
    -> chk_ev;
  endtask

  task automatic do_cfg(input logic [15:0] d, input string tag);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d;
    m_inv = d[7:0]; m_cs = d[15:8];
    push_exp(tag);
    @(negedge clk);
    cfg_we = 1'b0;
    -> chk_ev;
  endtask

  // monitor: compare outputs against scoreboard after each write
  initial forever begin
    @(chk_ev);
    while (exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({cs_sel, pad_out} !== e) begin
        errors++;
        $display("FAIL %s: actual cs=%h pad=%h expected cs=%h pad=%h",
                 t, cs_sel, pad_out, e[15:8], e[7:0]);
      end
    end
  end

  initial begin
    m_lvl = 8'hFF; m_inv = 8'h00; m_cs = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++; // R1 reset state
    if (pad_out !== 8'hFF || cs_sel !== 8'h00) begin
      errors++;
      $display("FAIL R1: actual cs=%h pad=%h expected cs=00 pad=ff", cs_sel, pad_out);
    end
    do_cmd(16'h00FF, "R3 clear all");
    do_cmd(16'h0500, "R2 set pins 0,2");
    do_cmd(16'h3030, "R4 set+clear same pins");
    do_cmd(16'h8001, "R5 set 7 clear 0 others hold");
    do_cmd(16'h0000, "R5 empty command");
    do_cfg(16'hA50F, "R7/R6 flags and inversion");
    do_cfg(16'h0000, "R8/R10 zero config restores levels");
    do_cfg(16'h3CFF, "R6 full inversion");
    do_cmd(16'h4200, "R11 set under inversion");
    do_cmd(16'hFF00, "R9 all high");
    do_cfg(16'h0000, "R8 zero config");
    do_cmd(16'hFFFF, "R4 all both");
    do_cmd(16'hFF00, "R9 all high again");
    repeat (2) @(negedge clk);
    checks++; // R10 idle hold
    if (pad_out !== 8'hFF) begin
      errors++;
      $display("FAIL R10: actual pad=%h expected pad=ff", pad_out);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule